// File: doc/BRIEF.md
# Four-Channel Coarse-Step PWM Generator

This block drives four independent pulse-width-modulated outputs from one reference clock. Each channel has a frequency byte, a duty byte, a polarity-invert bit and an enable bit. A host writes and reads all of them through a simple parallel byte port at fixed addresses.

The frequency byte holds a two-bit range selector and a six-bit multiplier. The channel frequency is the step size of the selected range times (multiplier + 1). The ranges have steps of 0.5, 2, 8 and 32 Hz, so a channel spans 0.5 Hz to 2048 Hz. Each channel divides the reference clock with a phase accumulator. The accumulator produces ticks at 256 times the programmed frequency, and the ticks advance an 8-bit phase counter. The duty byte D sets an active time of (D + 1)/256 of the period, so the output can never reach a 0 % duty cycle. A new setting acts on the next clock and does not realign the running counters, so a period caught mid-change mixes the old and new settings.

Top module: `cpwm_top`

## Requirements
- R1: Frequency register layout: bits [7:6] select the range (0: 0.5 Hz, 1: 2 Hz, 2: 8 Hz, 3: 32 Hz steps) and bits [5:0] hold a count c. The output period in reference clocks is REF_CLK_HZ / ((c + 1) × step).
- R2: For duty byte D, a non-inverted enabled output is high for (D + 1)/256 of each period. D = 0 gives 1/256 of the period, and D = 255 keeps the output high all the time.
- R3: Bit x of the polarity register at address 0x05 inverts channel x, so the channel is high for (255 − D)/256 of the period.
- R4: Bit 4 + x of the enable register at address 0x07 enables channel x. While the channel is disabled its output is low, whatever its polarity bit.
- R5: The frequency bytes of channels 0..3 are at addresses 0x08..0x0B. The duty bytes of channels 0..3 are at addresses 0x0C..0x0F.
- R6: A read strobe returns the full byte last written to a mapped address on rdata_o one clock later.
- R7: Addresses outside 0x05, 0x07 and 0x08..0x0F read as zero. Writes to them change no register and no output.
- R8: After reset every register reads zero and every output is low.
- R9: A register write acts on the output one clock after the write edge. The phase counter is neither reset nor realigned by the write, so the next period start keeps its original cadence.
- R10: The four channels run independently, each at its own frequency, duty and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock at REF_CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, valid one clock after re_i |
| pwm_o | output | 4 | Channel outputs, bit x is channel x |

## Verification
A written register is visible in its flops at the write edge. A read strobe yields data one edge later, and the bench samples rdata_o at the falling edge after that edge. The registered output reflects a new duty or polarity one edge after the write edge, so the bench samples the pin at the first falling edge after the write and expects the old level, then at the next falling edge and expects the new level. Period and high time are measured only from the second rising edge after a change, so each measured cycle runs wholly under the new setting. The reference clock is scaled so that every tick interval is an exact integer number of clocks.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int CH_N   = 4;
  localparam int CH_W   = $clog2(CH_N);
  localparam int A_POL  = 'h05;
  localparam int A_EN   = 'h07;
  localparam int A_FREQ = 'h08;
  localparam int A_DUTY = 'h0C;
  localparam int EN_LSB = 4;
  localparam int INC_W  = 20;  // (63+1) << 13 needs 20 bits

  typedef enum logic [2:0] {SEL_NONE, SEL_POL, SEL_EN, SEL_FREQ, SEL_DUTY} reg_sel_e;

  typedef struct packed {
    logic [1:0] rng;
    logic [5:0] mult;
    logic [7:0] duty;
    logic       inv;
    logic       en;
  } ch_cfg_t;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    we_i,
  input  logic [7:0]              wdata_i,
  input  logic                    re_i,
  output logic [7:0]              rdata_o,
  output ch_cfg_t [CH_N-1:0]      cfg_o
);
  logic [7:0]                pol_q, en_q, rdata_q;
  logic [CH_N-1:0][7:0]      freq_q, duty_q;
  reg_sel_e                  sel;
  logic [CH_W-1:0]           idx;

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (addr_i == ADDR_W'(A_POL)) begin
      sel = SEL_POL;
    end else if (addr_i == ADDR_W'(A_EN)) begin
      sel = SEL_EN;
    end else if (addr_i >= ADDR_W'(A_FREQ) && addr_i < ADDR_W'(A_FREQ + CH_N)) begin
      sel = SEL_FREQ;
      idx = CH_W'(addr_i - ADDR_W'(A_FREQ));
    end else if (addr_i >= ADDR_W'(A_DUTY) && addr_i < ADDR_W'(A_DUTY + CH_N)) begin
      sel = SEL_DUTY;
      idx = CH_W'(addr_i - ADDR_W'(A_DUTY));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= '0;
      en_q   <= '0;
      freq_q <= '0;
      duty_q <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_POL:  pol_q       <= wdata_i;
        SEL_EN:   en_q        <= wdata_i;
        SEL_FREQ: freq_q[idx] <= wdata_i;
        SEL_DUTY: duty_q[idx] <= wdata_i;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (re_i) begin
      case (sel)
        SEL_POL:  rdata_q <= pol_q;
        SEL_EN:   rdata_q <= en_q;
        SEL_FREQ: rdata_q <= freq_q[idx];
        SEL_DUTY: rdata_q <= duty_q[idx];
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_cfg
    assign cfg_o[ch].rng  = freq_q[ch][7:6];
    assign cfg_o[ch].mult = freq_q[ch][5:0];
    assign cfg_o[ch].duty = duty_q[ch];
    assign cfg_o[ch].inv  = pol_q[ch];
    assign cfg_o[ch].en   = en_q[EN_LSB + ch];
  end

  // R7
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_NONE) |=> ($stable(pol_q) && $stable(en_q) && $stable(freq_q) && $stable(duty_q)));
endmodule

// File: rtl/cpwm_rate_div.sv
module cpwm_rate_div
  import cpwm_pkg::*;
#(
  parameter int unsigned REF_HZ = 50_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rng_i,
  input  logic [5:0] mult_i,
  output logic       tick_o
);
  localparam int ACC_W = $clog2(REF_HZ) + 1;

  logic [6:0]       base;
  logic [INC_W-1:0] inc;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_q;
  logic             tick_q, wrap;

  // tick rate = 256 * step * (mult+1) = (mult+1) * 128 * 4^rng
  assign base = {1'b0, mult_i} + 7'd1;
  always_comb begin
    case (rng_i)
      2'd0:    inc = INC_W'(base) << 7;
      2'd1:    inc = INC_W'(base) << 9;
      2'd2:    inc = INC_W'(base) << 11;
      default: inc = INC_W'(base) << 13;
    endcase
  end

  assign sum  = {1'b0, acc_q} + (ACC_W+1)'(inc);
  assign wrap = sum >= (ACC_W+1)'(REF_HZ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= wrap ? ACC_W'(sum - (ACC_W+1)'(REF_HZ)) : ACC_W'(sum);
      tick_q <= wrap;
    end
  end

  assign tick_o = tick_q;

  // R1
  acc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < ACC_W'(REF_HZ));
endmodule

// File: rtl/cpwm_chan.sv
module cpwm_chan
  import cpwm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  ch_cfg_t cfg_i,
  output logic    pwm_o
);
  logic [7:0] phase_q;
  logic       pwm_q, active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= '0;
    else if (tick_i) phase_q <= phase_q + 8'd1;
  end

  assign active = phase_q <= cfg_i.duty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= cfg_i.en & (active ^ cfg_i.inv);
  end

  assign pwm_o = pwm_q;

  // R4
  dis_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> !pwm_o);
  // R2
  full_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && !cfg_i.inv && cfg_i.duty == 8'hFF) |=> pwm_o);
  // R9
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_q));
  // R9
  phase_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> phase_q == $past(phase_q) + 8'd1);
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int unsigned REF_CLK_HZ = 50_000_000,
  parameter int          ADDR_W     = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  input  logic              re_i,
  output logic [7:0]        rdata_o,
  output logic [CH_N-1:0]   pwm_o
);
  ch_cfg_t [CH_N-1:0] cfg;
  logic    [CH_N-1:0] tick;

  cpwm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .re_i    (re_i),
    .rdata_o (rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    cpwm_rate_div #(.REF_HZ(REF_CLK_HZ)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rng_i  (cfg[ch].rng),
      .mult_i (cfg[ch].mult),
      .tick_o (tick[ch])
    );
    cpwm_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick[ch]),
      .cfg_i  (cfg[ch]),
      .pwm_o  (pwm_o[ch])
    );
  end

  // R8
  rst_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> pwm_o == '0);
endmodule

// File: tb/cpwm_top_tb.sv
module cpwm_top_tb;
  localparam int unsigned REF = 524288;  // every tick interval is an exact clock count
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [3:0]    pwm;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {int ch; int per; int hi; string tag;} exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  cpwm_top #(.REF_CLK_HZ(REF), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .re_i(re), .rdata_o(rdata), .pwm_o(pwm)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=%0d", cyc, 180000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp_v);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp_v, input string tag);
    @(negedge clk);
    addr = AW'(a); re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    chk(rdata == 8'(exp_v), tag, rdata, exp_v);
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    prev = pwm[ch];
    for (int g = 0; g < 40000; g++) begin
      @(negedge clk);
      if (!prev && pwm[ch]) break;
      prev = pwm[ch];
    end
  endtask

  task automatic meas(input int ch, output int per, output int hi);
    logic prev;
    wait_rise(ch);
    per = 0; hi = 0;
    for (int g = 0; g < 40000; g++) begin
      if (pwm[ch]) hi++;
      per++;
      prev = pwm[ch];
      @(negedge clk);
      if (!prev && pwm[ch]) break;
    end
  endtask

  // driver side: push expected shape
  task automatic expect_shape(input int ch, input int per, input int hi, input string tag);
    exp_t e;
    e.ch = ch; e.per = per; e.hi = hi; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor side: pop and compare against measured output
  task automatic monitor_drain();
    exp_t e;
    int p, h;
    while (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      meas(e.ch, p, h);   // discard a cycle that may straddle a change
      meas(e.ch, p, h);
      chk(p == e.per, {e.tag, " period"}, p, e.per);
      chk(h == e.hi,  {e.tag, " high"},   h, e.hi);
    end
  endtask

  task automatic level_for(input int ch, input int n, input logic lvl, input string tag);
    int miss = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm[ch] !== lvl) miss++;
    end
    chk(miss == 0, tag, miss, 0);
  endtask

  initial begin
    int t;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(pwm == 4'h0, "R8 outputs low", pwm, 0);
    rd_chk('h05, 0, "R8 pol reset");
    rd_chk('h07, 0, "R8 en reset");
    for (int a = 'h08; a <= 'h0F; a++) rd_chk(a, 0, "R8 cfg reset");

    wr('h05, 'hA5); rd_chk('h05, 'hA5, "R6 pol readback");
    wr('h0A, 'h3C); rd_chk('h0A, 'h3C, "R6 freq readback");
    wr('h0E, 'h9D); rd_chk('h0E, 'h9D, "R6 duty readback");
    wr('h05, 'h00);

    wr('h03, 'hFF); wr('h06, 'hFF); wr('h10, 'hFF); wr('h04, 'hFF);
    rd_chk('h03, 0, "R7 unmapped 03");
    rd_chk('h10, 0, "R7 unmapped 10");
    rd_chk('h05, 0, "R7 pol untouched");
    rd_chk('h07, 0, "R7 en untouched");
    level_for(0, 50, 1'b0, "R7 outputs stay low");

    // ch0: range 3, count 63 -> 1 clock per tick, period 256
    wr('h08, 'hFF); wr('h0C, 'h3F); wr('h07, 'h10);
    expect_shape(0, 256, 64, "R1 R5 ch0 d63");
    monitor_drain();
    wr('h0C, 'h00);
    expect_shape(0, 256, 1, "R2 duty min");
    monitor_drain();
    wr('h0C, 'hFF);
    repeat (2) @(negedge clk);
    level_for(0, 600, 1'b1, "R2 duty full on");

    // all four channels at distinct settings
    wr('h0C, 'h3F);
    wr('h09, 'hDF); wr('h0D, 'h7F);   // r3 c31: 2 clk/tick
    wr('h0A, 'hBF); wr('h0E, 'h1F);   // r2 c63: 4 clk/tick
    wr('h0B, 'hCF); wr('h0F, 'hBF);   // r3 c15: 4 clk/tick
    wr('h07, 'hF0);
    expect_shape(0, 256, 64, "R10 ch0");
    expect_shape(1, 512, 256, "R10 ch1");
    expect_shape(2, 1024, 128, "R10 ch2");
    expect_shape(3, 1024, 768, "R10 ch3");
    monitor_drain();

    // lower ranges
    wr('h09, 'h7F);                   // r1 c63: 16 clk/tick
    wr('h0B, 'h3F); wr('h0F, 'h7F);   // r0 c63: 64 clk/tick
    expect_shape(1, 4096, 2048, "R1 range1");
    expect_shape(3, 16384, 8192, "R1 range0");
    monitor_drain();

    // polarity on ch2
    wr('h05, 'h04);
    expect_shape(2, 1024, 896, "R3 ch2 inverted");
    expect_shape(1, 4096, 2048, "R3 ch1 unaffected");
    monitor_drain();

    // disable inverted ch2
    wr('h07, 'hB0);
    @(negedge clk);
    level_for(2, 1200, 1'b0, "R4 disabled low");
    expect_shape(0, 256, 64, "R4 ch0 still runs");
    monitor_drain();

    // mid-period duty change on ch0
    wr('h0C, 'h7F);
    wait_rise(0);
    wait_rise(0);
    repeat (10) @(negedge clk);
    t = 10;
    @(negedge clk);
    addr = AW'('h0C); wdata = 8'h05; we = 1'b1;
    @(negedge clk);
    we = 1'b0; t += 2;
    chk(pwm[0] == 1'b1, "R9 old level before effect", pwm[0], 1);
    @(negedge clk); t++;
    chk(pwm[0] == 1'b0, "R9 new duty next clock", pwm[0], 0);
    begin
      logic prev;
      prev = pwm[0];
      for (int g = 0; g < 1000; g++) begin
        @(negedge clk); t++;
        if (!prev && pwm[0]) break;
        prev = pwm[0];
      end
    end
    chk(t == 256, "R9 cadence kept", t, 256);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule